// File: doc/BRIEF.md
# Planar 4:2:0 to Packed YUYV Line Converter

This block turns one frame held as three planes into packed 4:2:2 lines. The luma plane has full resolution. The two chroma planes are subsampled by two both across and down. Luma arrives as pairs of samples on one ready/valid stream, and the U and V samples arrive on two more streams of their own. Each output word carries two luma samples and the chroma pair they share.

A chroma row covers two luma rows. On an even luma row the block takes U and V from their streams and keeps a copy in a small line store. On the odd row that follows, it reads the chroma back from that store and leaves the chroma streams untouched.

After the pixel words of each line, the block appends zero-valued padding words. These fill the line up to the next alignment boundary, but never exceed the configured padding size. The rest of the configured padding is reported as a skip byte count on the final word of the line. A start pulse latches width, height and padding, and a one-cycle pulse marks the end of the frame.

Top module: `yuv420_packer`

## Requirements
- R1: Each output word holds, from bit 0 upward, luma sample 2c of the line in bits 7:0, U sample c in bits 15:8, luma sample 2c+1 in bits 23:16 and V sample c in bits 31:24. On the luma stream, bits 7:0 carry the even pixel and bits 15:8 the odd pixel.
- R2: Luma rows 2k and 2k+1 both use chroma row k. On odd rows `u_ready` and `v_ready` stay low, and a frame consumes exactly (height/2)·(width/2) beats from each chroma stream.
- R3: Each line starts with exactly width/2 pixel words, and the frame takes exactly height·width/2 luma beats.
- R4: After the pixel words, the line carries P/4 words of value zero, where P is the smaller of the padding size and (ALIGN − (2·width mod ALIGN)) mod ALIGN. ALIGN defaults to 32 bytes.
- R5: `out_skip` equals padding size minus P on the final word of each line, and is zero on every other word.
- R6: `out_last` is high on the final word of each line (a padding word when P > 0) and low on all other words.
- R7: `frame_done` is high for exactly one cycle, the cycle after the final word of the final line is accepted. `busy` is low from that cycle on.
- R8: A start with an odd or zero width, an odd or zero height, a width above MAX_W or a padding size that is not a multiple of 4 sets `cfg_err`. The block then stays idle, accepts no input and emits no word. The next accepted start clears `cfg_err`.
- R9: While `out_valid` is high and `out_ready` is low, the output word and flags hold steady and no input beat is accepted.
- R10: While idle, no input stream is given ready and no word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch configuration and begin a frame (used only while idle) |
| cfg_width | input | W_BITS | Frame width in pixels |
| cfg_height | input | H_BITS | Frame height in lines |
| cfg_pad | input | PAD_BITS | Padding size per line in bytes |
| y_valid | input | 1 | Luma pair valid |
| y_ready | output | 1 | Luma pair accepted |
| y_data | input | 16 | Two luma samples, even pixel in bits 7:0 |
| u_valid | input | 1 | U sample valid |
| u_ready | output | 1 | U sample accepted |
| u_data | input | 8 | U sample |
| v_valid | input | 1 | V sample valid |
| v_ready | output | 1 | V sample accepted |
| v_data | input | 8 | V sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed word |
| out_last | output | 1 | Final word of a line |
| out_skip | output | PAD_BITS | Padding bytes skipped, on the final word of a line |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start carried an illegal configuration |

## Verification
A wrong row parity shows up within the first word of the second line. Either the chroma streams get ready on an odd row, or the odd line carries chroma that does not match its even partner. A column or padding counter that slips moves `out_last` and `out_skip` to the wrong word in the very first line, and it changes the number of words per line. A line counter that goes wrong makes `frame_done` appear too early or too late against the word count, or lets the consumed chroma beats drift away from half the luma rows.

// File: rtl/yuvpk_pkg.sv
package yuvpk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_PAD   = 2'd2,
    PH_DRAIN = 2'd3
  } phase_t;

  // bytes needed to bring one packed line to the next alignment boundary
  function automatic int unsigned fill_to_align(input int unsigned width_px,
                                                input int unsigned align);
    int unsigned rem;
    rem = (2 * width_px) % align;
    return (rem == 0) ? 0 : align - rem;
  endfunction

  // padding bytes actually written after the pixel words of a line
  function automatic int unsigned pad_written(input int unsigned width_px,
                                              input int unsigned pad_bytes,
                                              input int unsigned align);
    int unsigned fill;
    fill = fill_to_align(width_px, align);
    return (pad_bytes < fill) ? pad_bytes : fill;
  endfunction

  function automatic bit cfg_valid(input int unsigned w, input int unsigned h,
                                   input int unsigned pad,
                                   input int unsigned max_w,
                                   input int unsigned max_h);
    return (w != 0) && (w % 2 == 0) && (w <= max_w) &&
           (h != 0) && (h % 2 == 0) && (h <= max_h) &&
           (pad % 4 == 0);
  endfunction

endpackage

// File: rtl/yuvpk_chroma_buf.sv
module yuvpk_chroma_buf #(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data
);

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/yuvpk_seq.sv
module yuvpk_seq
  import yuvpk_pkg::*;
#(
  parameter int CW      = 6,
  parameter int H_BITS  = 7,
  parameter int PW_BITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               adv,
  input  logic               drain_ack,
  input  logic [CW-1:0]      half_w,
  input  logic [H_BITS-1:0]  height,
  input  logic [PW_BITS-1:0] pad_words,
  output phase_t             phase,
  output logic [CW-1:0]      col,
  output logic [H_BITS-1:0]  row,
  output logic               word_last,
  output logic               word_final,
  output logic               frame_done
);

  logic [PW_BITS-1:0] padcnt;
  logic data_end, has_pad, pad_end, last_row;

  assign data_end   = (col == half_w - CW'(1));
  assign has_pad    = (pad_words != '0);
  assign pad_end    = (padcnt == pad_words - PW_BITS'(1));
  assign last_row   = (row == height - H_BITS'(1));
  assign word_last  = ((phase == PH_DATA) && data_end && !has_pad) ||
                      ((phase == PH_PAD) && pad_end);
  assign word_final = word_last && last_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      col        <= '0;
      row        <= '0;
      padcnt     <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (go) begin
            phase  <= PH_DATA;
            col    <= '0;
            row    <= '0;
            padcnt <= '0;
          end
        end
        PH_DATA: begin
          if (adv) begin
            if (!data_end) begin
              col <= col + CW'(1);
            end else begin
              col <= '0;
              if (has_pad) begin
                phase  <= PH_PAD;
                padcnt <= '0;
              end else if (last_row) begin
                phase <= PH_DRAIN;
              end else begin
                row <= row + H_BITS'(1);
              end
            end
          end
        end
        PH_PAD: begin
          if (adv) begin
            padcnt <= padcnt + PW_BITS'(1);
            if (pad_end) begin
              if (last_row) begin
                phase <= PH_DRAIN;
              end else begin
                phase <= PH_DATA;
                row   <= row + H_BITS'(1);
              end
            end
          end
        end
        PH_DRAIN: begin
          if (drain_ack) begin
            phase      <= PH_IDLE;
            frame_done <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/yuvpk_pack.sv
module yuvpk_pack #(
  parameter int PAD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                zero_word,
  input  logic [15:0]         y_pair,
  input  logic [7:0]          u_byte,
  input  logic [7:0]          v_byte,
  input  logic                last_in,
  input  logic [PAD_BITS-1:0] skip_in,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [31:0]         out_data,
  output logic                out_last,
  output logic [PAD_BITS-1:0] out_skip,
  output logic                free
);

  logic [31:0] word_next;

  assign word_next = zero_word ? 32'd0 : {v_byte, y_pair[15:8], u_byte, y_pair[7:0]};
  assign free      = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_skip  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= word_next;
      out_last  <= last_in;
      out_skip  <= skip_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/yuv420_packer.sv
module yuv420_packer
  import yuvpk_pkg::*;
#(
  parameter int          MAX_W    = 64,
  parameter int          MAX_H    = 64,
  parameter int          PAD_BITS = 8,
  parameter int unsigned ALIGN    = 32,
  localparam int W_BITS = $clog2(MAX_W + 1),
  localparam int H_BITS = $clog2(MAX_H + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [W_BITS-1:0]   cfg_width,
  input  logic [H_BITS-1:0]   cfg_height,
  input  logic [PAD_BITS-1:0] cfg_pad,
  input  logic                y_valid,
  output logic                y_ready,
  input  logic [15:0]         y_data,
  input  logic                u_valid,
  output logic                u_ready,
  input  logic [7:0]          u_data,
  input  logic                v_valid,
  output logic                v_ready,
  input  logic [7:0]          v_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_data,
  output logic                out_last,
  output logic [PAD_BITS-1:0] out_skip,
  output logic                frame_done,
  output logic                busy,
  output logic                cfg_err
);

  localparam int CW    = W_BITS - 1;
  localparam int DEPTH = MAX_W / 2;
  localparam int CA    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW    = PAD_BITS - 2;

  phase_t              phase;
  logic [CW-1:0]       col, lat_hw;
  logic [H_BITS-1:0]   row, lat_h;
  logic [PW-1:0]       lat_pww;
  logic [PAD_BITS-1:0] lat_skip, pw_calc;
  logic                cfg_ok, start_ok, go;
  logic                word_last, word_final, free;
  logic                row_odd, chroma_ok, fire_data, fire_pad, load, drain_ack;
  logic [15:0]         buf_rd;
  logic [7:0]          u_sel, v_sel;

  // configuration check and latch
  assign cfg_ok   = cfg_valid(32'(cfg_width), 32'(cfg_height), 32'(cfg_pad),
                              MAX_W, MAX_H);
  assign start_ok = start && (phase == PH_IDLE);
  assign go       = start_ok && cfg_ok;
  assign pw_calc  = PAD_BITS'(pad_written(32'(cfg_width), 32'(cfg_pad), ALIGN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err  <= 1'b0;
      lat_hw   <= '0;
      lat_h    <= '0;
      lat_pww  <= '0;
      lat_skip <= '0;
    end else if (start_ok) begin
      cfg_err <= !cfg_ok;
      if (cfg_ok) begin
        lat_hw   <= cfg_width[W_BITS-1:1];
        lat_h    <= cfg_height;
        lat_pww  <= pw_calc[PAD_BITS-1:2];
        lat_skip <= cfg_pad - pw_calc;
      end
    end
  end

  // named events for the checker
  assign row_odd   = row[0];
  assign chroma_ok = row_odd || (u_valid && v_valid);
  assign fire_data = (phase == PH_DATA) && free && y_valid && chroma_ok;
  assign fire_pad  = (phase == PH_PAD) && free;
  assign load      = fire_data || fire_pad;
  assign drain_ack = (phase == PH_DRAIN) && out_valid && out_ready;

  assign y_ready = fire_data;
  assign u_ready = fire_data && !row_odd;
  assign v_ready = fire_data && !row_odd;
  assign busy    = (phase != PH_IDLE);

  yuvpk_seq #(.CW(CW), .H_BITS(H_BITS), .PW_BITS(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .adv        (load),
    .drain_ack  (drain_ack),
    .half_w     (lat_hw),
    .height     (lat_h),
    .pad_words  (lat_pww),
    .phase      (phase),
    .col        (col),
    .row        (row),
    .word_last  (word_last),
    .word_final (word_final),
    .frame_done (frame_done)
  );

  yuvpk_chroma_buf #(.DEPTH(DEPTH)) u_cbuf (
    .clk     (clk),
    .wr_en   (u_ready),
    .wr_addr (col[CA-1:0]),
    .wr_data ({v_data, u_data}),
    .rd_addr (col[CA-1:0]),
    .rd_data (buf_rd)
  );

  assign u_sel = row_odd ? buf_rd[7:0]  : u_data;
  assign v_sel = row_odd ? buf_rd[15:8] : v_data;

  yuvpk_pack #(.PAD_BITS(PAD_BITS)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .zero_word (fire_pad),
    .y_pair    (y_data),
    .u_byte    (u_sel),
    .v_byte    (v_sel),
    .last_in   (word_last),
    .skip_in   (word_last ? lat_skip : '0),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_skip  (out_skip),
    .free      (free)
  );

endmodule

// File: rtl/yuv420_packer_chk.sv
module yuv420_packer_chk #(
  parameter int PAD_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                y_ready,
  input logic                u_ready,
  input logic                v_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [31:0]         out_data,
  input logic                out_last,
  input logic [PAD_BITS-1:0] out_skip,
  input logic                frame_done,
  input logic                busy,
  input logic                cfg_err,
  input logic                row_odd,
  input logic                fire_pad
);

  // R9: a stalled word is held unchanged
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_last) && $stable(out_skip));

  // R9: no input is taken while the output is blocked
  assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !y_ready && !u_ready && !v_ready);

  // R2: odd luma rows leave the chroma streams alone
  assert_odd_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_odd |-> !u_ready && !v_ready);

  // R2: U and V are taken together
  assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    u_ready == v_ready);

  // R4: a padding slot yields a zero word
  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_pad |=> out_valid && out_data == 32'd0);

  // R5: skip count only on line ends
  assert_skip_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_skip == '0);

  // R7: frame_done is a single-cycle pulse with the block idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);

  // R8: a rejected configuration keeps the block silent
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !out_valid);

  // R10: nothing accepted while idle
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !y_ready && !u_ready && !v_ready);

endmodule

bind yuv420_packer yuv420_packer_chk #(.PAD_BITS(PAD_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .y_ready    (y_ready),
  .u_ready    (u_ready),
  .v_ready    (v_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .out_skip   (out_skip),
  .frame_done (frame_done),
  .busy       (busy),
  .cfg_err    (cfg_err),
  .row_odd    (row_odd),
  .fire_pad   (fire_pad)
);

// File: tb/tb_yuv420_packer.sv
`timescale 1ns/1ps
module tb_yuv420_packer;

  localparam int MAX_W = 64;
  localparam int MAX_H = 64;
  localparam int PB    = 8;
  localparam int WB    = $clog2(MAX_W + 1);
  localparam int HB    = $clog2(MAX_H + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [WB-1:0] cfg_width = '0;
  logic [HB-1:0] cfg_height = '0;
  logic [PB-1:0] cfg_pad = '0;
  logic          y_valid = 1'b0, u_valid = 1'b0, v_valid = 1'b0;
  logic          y_ready, u_ready, v_ready;
  logic [15:0]   y_data = '0;
  logic [7:0]    u_data = '0, v_data = '0;
  logic          out_valid, out_last, frame_done, busy, cfg_err;
  logic          out_ready = 1'b1;
  logic [31:0]   out_data;
  logic [PB-1:0] out_skip;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  yuv420_packer #(.MAX_W(MAX_W), .MAX_H(MAX_H), .PAD_BITS(PB), .ALIGN(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_pad(cfg_pad),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
    .u_valid(u_valid), .u_ready(u_ready), .u_data(u_data),
    .v_valid(v_valid), .v_ready(v_ready), .v_data(v_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_skip(out_skip),
    .frame_done(frame_done), .busy(busy), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ypix(input int r, input int x);
    return 8'(r * 17 + x * 3 + 1);
  endfunction
  function automatic logic [7:0] upix(input int r, input int c);
    return 8'(r * 29 + c * 5 + 64);
  endfunction
  function automatic logic [7:0] vpix(input int r, input int c);
    return 8'(r * 13 + c * 7 + 128);
  endfunction

  task automatic pulse_start(input int w, input int h, input int pad);
    @(negedge clk);
    cfg_width  = WB'(w);
    cfg_height = HB'(h);
    cfg_pad    = PB'(pad);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // reset state
  task automatic t_reset();
    #1;
    check(!out_valid && !busy && !cfg_err && !frame_done, "R7", "reset outputs quiet",
          {out_valid, busy, cfg_err, frame_done}, 0);
    check(!y_ready && !u_ready && !v_ready, "R10", "reset readies low",
          {y_ready, u_ready, v_ready}, 0);
  endtask

  // idle: offered inputs are left untouched
  task automatic t_idle();
    bit seen = 0;
    @(negedge clk);
    y_valid = 1; u_valid = 1; v_valid = 1;
    for (int i = 0; i < 8; i++) begin
      #1;
      if (y_ready || u_ready || v_ready || out_valid) seen = 1;
      @(negedge clk);
    end
    y_valid = 0; u_valid = 0; v_valid = 0;
    check(!seen, "R10", "idle accepts nothing", seen, 0);
  endtask

  // rejected configuration
  task automatic t_bad(input int w, input int h, input int pad);
    bit seen = 0;
    pulse_start(w, h, pad);
    y_valid = 1; u_valid = 1; v_valid = 1;
    #1;
    check(cfg_err && !busy, "R8", $sformatf("cfg_err for %0dx%0d pad %0d", w, h, pad),
          {cfg_err, busy}, 2'b10);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #1;
      if (y_ready || u_ready || v_ready || out_valid || busy) seen = 1;
    end
    check(!seen, "R8", "rejected frame stays silent", seen, 0);
    @(negedge clk);
    y_valid = 0; u_valid = 0; v_valid = 0;
  endtask

  // one complete frame with optional output stalls and input gaps
  task automatic run_frame(input int w, input int h, input int pad,
                           input bit stall, input bit gaps);
    int hw    = w / 2;
    int rem   = (2 * w) % 32;
    int fill  = (rem == 0) ? 0 : 32 - rem;
    int pw    = (pad < fill) ? pad : fill;
    int wpl   = hw + pw / 4;
    int skip  = pad - pw;
    int total = h * wpl;
    int yk = 0, ck = 0, oi = 0, cyc = 0;
    bit hy = 0, hc = 0, fin_prev = 0, done_seen = 0, stall_prev = 0;
    logic [31:0] data_prev = '0;
    string tag = $sformatf("%0dx%0d pad %0d", w, h, pad);

    pulse_start(w, h, pad);
    #1;
    check(busy && !cfg_err, "R8", {"accepted start ", tag}, {busy, cfg_err}, 2'b10);
    while (!done_seen && cyc < 20000) begin
      @(negedge clk);
      if (hy) yk++;
      if (hc) ck++;
      y_valid = !(gaps && cyc % 4 == 1) && (yk < h * hw);
      y_data  = {ypix(yk / hw, 2 * (yk % hw) + 1), ypix(yk / hw, 2 * (yk % hw))};
      u_valid = !(gaps && cyc % 5 == 2) && (ck < (h / 2) * hw);
      v_valid = u_valid;
      u_data  = upix(ck / hw, ck % hw);
      v_data  = vpix(ck / hw, ck % hw);
      out_ready = !(stall && (cyc % 3 == 1));
      #1;
      hy = y_valid && y_ready;
      hc = u_valid && u_ready;
      if (stall_prev)
        check(out_valid && out_data == data_prev, "R9", "stalled word held",
              out_data, data_prev);
      if (out_valid && !out_ready)
        check(!y_ready && !u_ready, "R9", "no input taken under stall",
              {y_ready, u_ready}, 0);
      stall_prev = out_valid && !out_ready;
      data_prev  = out_data;
      if (fin_prev) begin
        check(frame_done && !busy, "R7", {"frame_done after final word ", tag},
              {frame_done, busy}, 2'b10);
        done_seen = 1;
      end else if (frame_done) begin
        check(0, "R7", {"frame_done too early ", tag}, oi, total);
        done_seen = 1;
      end
      fin_prev = 0;
      if (out_valid && out_ready && !done_seen) begin
        int line = oi / wpl;
        int pos  = oi % wpl;
        logic [31:0] exp_w;
        bit exp_last = (pos == wpl - 1);
        if (pos < hw) begin
          exp_w = {vpix(line / 2, pos), ypix(line, 2 * pos + 1),
                   upix(line / 2, pos), ypix(line, 2 * pos)};
          check(out_data == exp_w, (line % 2) ? "R2" : "R1",
                $sformatf("pixel word line %0d pos %0d %s", line, pos, tag),
                out_data, exp_w);
        end else begin
          check(out_data == 32'd0, "R4", $sformatf("pad word line %0d %s", line, tag),
                out_data, 0);
        end
        check(out_last == exp_last, "R6", $sformatf("line end flag word %0d %s", oi, tag),
              out_last, exp_last);
        check(out_skip == PB'(exp_last ? skip : 0), "R5",
              $sformatf("skip count word %0d %s", oi, tag), out_skip, exp_last ? skip : 0);
        fin_prev = (oi == total - 1);
        oi++;
      end
      cyc++;
    end
    @(negedge clk);
    y_valid = 0; u_valid = 0; v_valid = 0; out_ready = 1;
    check(done_seen, "R7", {"frame completed ", tag}, done_seen, 1);
    check(oi == total, "R3", {"words per frame ", tag}, oi, total);
    check(yk == h * hw, "R3", {"luma beats ", tag}, yk, h * hw);
    check(ck == (h / 2) * hw, "R2", {"chroma beats ", tag}, ck, (h / 2) * hw);
    #1;
    check(!frame_done, "R7", {"frame_done single cycle ", tag}, frame_done, 0);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    run_frame(8, 4, 48, 0, 0);   // 16 written, 32 skipped
    run_frame(16, 6, 12, 1, 0);  // aligned line: all padding skipped
    run_frame(6, 4, 8, 0, 1);    // padding fully written
    run_frame(10, 2, 40, 1, 1);  // 12 written, 28 skipped
    run_frame(64, 2, 0, 0, 0);   // widest line, no padding
    t_bad(7, 4, 0);
    t_bad(8, 3, 0);
    t_bad(8, 4, 6);
    t_bad(0, 2, 0);
    t_bad(66, 2, 0);
    run_frame(4, 2, 4, 1, 1);    // cfg_err cleared by good start
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule